// File: doc/BRIEF.md
# Fractional Phase Clock-Enable Divider Bank

This block derives clock-enable pulse trains from one fast reference clock. Each channel behaves like a fractional phase divider placed after a high-speed PLL. Its enable rate is the reference rate times 18 divided by a programmable fraction value, so the ratio moves in steps of one eighteenth. The output never runs faster than the reference. Several channels sit side by side. A write port picks a channel by a logical index, and the logical order is the reverse of the physical slot order.

Each channel has a one-byte control register. Bits 5:0 hold the fraction and bit 7 holds a gate. Software writes the byte directly or through set-bits and clear-bits aliases. The safe sequence sets the gate, writes the new fraction with the gate still set, then clears the gate.

A small state machine runs each channel. In state PG_GATED the accumulator is held at zero and the fraction is copied into the active value. The "release" transition to PG_RUN fires when the gate is clear. The "halt" transition back to PG_GATED fires when the gate is set. Both states hold themselves otherwise. In PG_RUN the accumulator adds 18 every cycle. When the sum reaches the active fraction, the channel emits one enable pulse, subtracts the fraction, and takes a fresh copy of the fraction.

Top module: `frac_phase_div`

## Requirements
- R1: In PG_RUN a channel emits exactly 18 pulses in any frac consecutive cycles counted from its first running cycle. The first running cycle is the second cycle after the gate-clearing write, and the accumulator starts there from zero. With a fraction of 18, every running cycle pulses.
- R2: Every write leaves the 6-bit fraction field (bits 5:0) clamped into 18..35. Values below 18 become 18 and values above 35 become 35. The read-back byte shows the stored, clamped value.
- R3: While gate bit 7 of a channel's control byte reads 1, that channel's pulse output stays 0. This holds from the first cycle the register shows the bit.
- R4: wr_op selects the write kind: 0 replaces the byte, 1 ORs wr_data into it, 2 clears the bits that are 1 in wr_data, and 3 changes nothing.
- R5: Logical index k (on wr_sel and rd_sel) addresses physical slot NUM_CH-1-k. Bit p of tick_o belongs to physical slot p. Writes to one channel leave the others untouched.
- R6: A running channel adopts a new fraction only in a cycle where it pulses. A write that lands on a pulse cycle is adopted at the following pulse. While gated, the fraction is adopted every cycle.
- R7: After reset every control byte reads 0x92 (gate set, fraction 18) and every pulse output is 0.
- R8: Bit 6 of every control byte always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 2 | Write kind: 0 replace, 1 set bits, 2 clear bits, 3 none |
| wr_sel | input | SEL_W | Logical channel index for the write |
| wr_data | input | 8 | Write byte |
| rd_sel | input | SEL_W | Logical channel index for read-back |
| rd_data | output | 8 | Control byte of the selected channel |
| tick_o | output | NUM_CH | Enable pulses, one bit per physical slot |

## Verification
The fraction write and the accumulator wrap can fall in the same cycle. In that case the register takes the new byte while the channel reloads its active fraction from the old one. The bench runs a channel at fraction 35 and drives a write of fraction 18 in exactly the cycle of its first pulse. It then checks that the next cycle stays quiet, as the old fraction requires, and that the new fraction shows only after the following pulse. The same overlap is watched continuously by a property that allows the active fraction to change only after a gated or pulsing cycle.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
    localparam int FRAC_W   = 6;
    localparam int BYTE_W   = 8;
    localparam int GATE_BIT = 7;
    localparam int STEP     = 18;
    localparam int FRAC_MIN = 18;
    localparam int FRAC_MAX = 35;
    localparam int ACC_W    = FRAC_W + 1;
    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h92;

    typedef enum logic [1:0] {
        OP_REPLACE = 2'd0,
        OP_SETBITS = 2'd1,
        OP_CLRBITS = 2'd2,
        OP_NONE    = 2'd3
    } wr_op_e;

    typedef enum logic {
        PG_GATED = 1'b0,
        PG_RUN   = 1'b1
    } pg_state_e;

    function automatic logic [FRAC_W-1:0] clamp_frac(input logic [FRAC_W-1:0] v);
        if (v < FRAC_W'(FRAC_MIN))      return FRAC_W'(FRAC_MIN);
        else if (v > FRAC_W'(FRAC_MAX)) return FRAC_W'(FRAC_MAX);
        else                            return v;
    endfunction
endpackage

// File: rtl/fpd_ctrl_reg.sv
module fpd_ctrl_reg
    import fpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [1:0]        op,
    input  logic [BYTE_W-1:0] data,
    output logic [BYTE_W-1:0] q
);
    logic [BYTE_W-1:0] raw;
    logic [BYTE_W-1:0] nxt;

    // Alias decode: replace, OR-in, or mask-out.
    always_comb begin
        unique case (wr_op_e'(op))
            OP_REPLACE: raw = data;
            OP_SETBITS: raw = q | data;
            OP_CLRBITS: raw = q & ~data;
            default:    raw = q;
        endcase
        nxt = '0;
        nxt[GATE_BIT]     = raw[GATE_BIT];
        nxt[FRAC_W-1:0]   = clamp_frac(raw[FRAC_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   q <= CTRL_RESET;
        else if (hit) q <= nxt;
    end
endmodule

// File: rtl/fpd_phase_gen.sv
module fpd_phase_gen
    import fpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate,
    input  logic [FRAC_W-1:0] frac_cfg,
    output logic [FRAC_W-1:0] act_frac,
    output logic              running,
    output logic              tick
);
    pg_state_e        state_q, state_d;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    always_comb begin
        sum  = acc_q + ACC_W'(STEP);
        wrap = sum >= ACC_W'(act_frac);
    end

    // Next-state: release when gate clears, halt when gate sets.
    always_comb begin
        unique case (state_q)
            PG_GATED: state_d = gate ? PG_GATED : PG_RUN;
            PG_RUN:   state_d = gate ? PG_GATED : PG_RUN;
            default:  state_d = PG_GATED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PG_GATED;
        else        state_q <= state_d;
    end

    // Accumulator and active fraction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            act_frac <= FRAC_W'(FRAC_MIN);
        end else begin
            unique case (state_q)
                PG_GATED: begin
                    acc_q    <= '0;
                    act_frac <= frac_cfg;
                end
                PG_RUN: begin
                    if (gate) begin
                        acc_q <= '0;
                    end else if (wrap) begin
                        acc_q    <= sum - ACC_W'(act_frac);
                        act_frac <= frac_cfg;
                    end else begin
                        acc_q <= sum;
                    end
                end
                default: acc_q <= '0;
            endcase
        end
    end

    // Output process.
    always_comb begin
        running = (state_q == PG_RUN);
        tick    = running && !gate && wrap;
    end
endmodule

// File: rtl/frac_phase_div.sv
module frac_phase_div
    import fpd_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_op,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [7:0]        wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [7:0]        rd_data,
    output logic [NUM_CH-1:0] tick_o
);
    logic [NUM_CH*BYTE_W-1:0] ctrl_flat;
    logic [NUM_CH*FRAC_W-1:0] act_flat;
    logic [NUM_CH-1:0]        run_flat;

    for (genvar p = 0; p < NUM_CH; p++) begin : g_slot
        localparam logic [SEL_W-1:0] LOGICAL = SEL_W'(NUM_CH - 1 - p);
        logic              hit;
        logic [BYTE_W-1:0] q;

        assign hit = wr_en && (wr_sel == LOGICAL);

        fpd_ctrl_reg u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .hit  (hit),
            .op   (wr_op),
            .data (wr_data),
            .q    (q)
        );

        fpd_phase_gen u_gen (
            .clk     (clk),
            .rst_n   (rst_n),
            .gate    (q[GATE_BIT]),
            .frac_cfg(q[FRAC_W-1:0]),
            .act_frac(act_flat[p*FRAC_W +: FRAC_W]),
            .running (run_flat[p]),
            .tick    (tick_o[p])
        );

        assign ctrl_flat[p*BYTE_W +: BYTE_W] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_CH; p++) begin
            if (rd_sel == SEL_W'(NUM_CH - 1 - p))
                rd_data = ctrl_flat[p*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker
    import fpd_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH*BYTE_W-1:0] ctrl_flat,
    input logic [NUM_CH*FRAC_W-1:0] act_flat,
    input logic [NUM_CH-1:0]        run_flat,
    input logic [NUM_CH-1:0]        tick
);
    for (genvar p = 0; p < NUM_CH; p++) begin : g_chk
        assert_frac_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_flat[p*BYTE_W +: FRAC_W] >= FRAC_W'(FRAC_MIN)) &&
            (ctrl_flat[p*BYTE_W +: FRAC_W] <= FRAC_W'(FRAC_MAX)) &&
            (act_flat[p*FRAC_W +: FRAC_W] >= FRAC_W'(FRAC_MIN)) &&
            (act_flat[p*FRAC_W +: FRAC_W] <= FRAC_W'(FRAC_MAX)));

        assert_gate_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_flat[p*BYTE_W + GATE_BIT] |-> !tick[p]);

        assert_load_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(act_flat[p*FRAC_W +: FRAC_W]) |->
                ($past(!run_flat[p]) || $past(tick[p])));

        assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_flat[p*BYTE_W + 6] == 1'b0);

        assert_pulse_needs_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
            tick[p] |-> run_flat[p]);
    end
endmodule

bind frac_phase_div fpd_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_flat(ctrl_flat),
    .act_flat (act_flat),
    .run_flat (run_flat),
    .tick     (tick_o)
);

// File: tb/tb_frac_phase_div.sv
module tb_frac_phase_div;
    localparam int NUM_CH = 2;
    localparam int SEL_W  = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_op = 2'd0;
    logic [SEL_W-1:0]  wr_sel = '0;
    logic [7:0]        wr_data = 8'h00;
    logic [SEL_W-1:0]  rd_sel = '0;
    logic [7:0]        rd_data;
    logic [NUM_CH-1:0] tick_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    frac_phase_div #(.NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .tick_o(tick_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at negedge, latch at next posedge, return at following negedge.
    task automatic wr(input int sel, input int op, input int data);
        wr_en   = 1'b1;
        wr_sel  = SEL_W'(sel);
        wr_op   = 2'(op);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int sel, output int v);
        rd_sel = SEL_W'(sel);
        #1;
        v = int'(rd_data);
    endtask

    task automatic program_ch(input int sel, input int frac);
        wr(sel, 1, 8'h80);
        wr(sel, 0, 8'h80 | frac);
        wr(sel, 2, 8'h80);
    endtask

    // Counts n+1 samples starting at the current negedge (first is the gated cycle).
    task automatic count_ticks(input int slot, input int n, output int c);
        c = 0;
        for (int i = 0; i <= n; i++) begin
            if (i > 0) @(negedge clk);
            c += int'(tick_o[slot]);
        end
    endtask

    task automatic t_reset;
        int v;
        for (int k = 0; k < NUM_CH; k++) begin
            rd(k, v);
            check(v == 8'h92, "R7 reset byte", v, 8'h92);
        end
        check(tick_o == '0, "R7 reset ticks", int'(tick_o), 0);
        begin
            int c = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                c += int'(tick_o != '0);
            end
            check(c == 0, "R3 gated at reset", c, 0);
        end
    endtask

    task automatic t_reverse_and_fast;
        int c;
        program_ch(0, 18);
        check(tick_o[1] == 1'b0, "R1 gated cycle after release", int'(tick_o[1]), 0);
        @(negedge clk);
        check(tick_o[1] == 1'b1, "R1 first running cycle frac18", int'(tick_o[1]), 1);
        check(tick_o[0] == 1'b0, "R5 other slot idle", int'(tick_o[0]), 0);
        c = 0;
        for (int i = 0; i < 36; i++) begin
            @(negedge clk);
            c += int'(tick_o[1]);
        end
        check(c == 36, "R1 frac18 every cycle", c, 36);
        wr(0, 1, 8'h80);
        check(tick_o[1] == 1'b0, "R3 gate set stops pulses", int'(tick_o[1]), 0);
    endtask

    task automatic t_rate35;
        int c;
        program_ch(1, 35);
        count_ticks(0, 140, c);
        check(c == 72, "R1 frac35 over 140 cycles", c, 72);
        check(tick_o[1] == 1'b0, "R5 slot1 untouched", int'(tick_o[1]), 0);
        wr(1, 1, 8'h80);
    endtask

    task automatic t_clamp_alias;
        int v;
        wr(1, 0, 8'h85);
        rd(1, v); check(v == 8'h92, "R2 low clamp", v, 8'h92);
        wr(1, 1, 8'h3F);
        rd(1, v); check(v == 8'hA3, "R2 R4 set alias high clamp", v, 8'hA3);
        wr(1, 3, 8'h00);
        rd(1, v); check(v == 8'hA3, "R4 op3 no effect", v, 8'hA3);
        wr(1, 2, 8'h3F);
        rd(1, v); check(v == 8'h92, "R4 clear alias clamps to 18", v, 8'h92);
        wr(1, 0, 8'h7F);
        rd(1, v); check(v == 8'h23, "R8 bit6 dropped", v, 8'h23);
        rd(0, v); check(v == 8'h92, "R5 other channel unchanged", v, 8'h92);
        wr(1, 1, 8'h80);
    endtask

    // Fraction write landing exactly on a pulse cycle of a frac35 run.
    task automatic t_write_on_wrap;
        program_ch(1, 35);
        @(negedge clk);
        check(tick_o[0] == 1'b0, "R6 c1 no pulse", int'(tick_o[0]), 0);
        @(negedge clk);
        check(tick_o[0] == 1'b1, "R6 c2 pulse", int'(tick_o[0]), 1);
        wr(1, 0, 8'h12);
        check(tick_o[0] == 1'b0, "R6 old fraction kept after wrap-cycle write", int'(tick_o[0]), 0);
        @(negedge clk);
        check(tick_o[0] == 1'b1, "R6 pulse on old fraction", int'(tick_o[0]), 1);
        @(negedge clk);
        check(tick_o[0] == 1'b1, "R6 new fraction adopted", int'(tick_o[0]), 1);
        wr(1, 1, 8'h80);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reverse_and_fast();
        t_rate35();
        t_clamp_alias();
        t_write_on_wrap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule